// File: doc/BRIEF.md
# Prescaled Up-Counting Timer

This block is an up-counting timer set up through a small write-only register port. Each count step is a "tick". An internal divider makes one tick every PSC+1 clock cycles. When the counter reaches its terminal value on a tick, it returns to zero and raises an update event. That event sets a sticky flag. Through separate enable bits, the event can also drive a level interrupt and a one-cycle DMA request pulse.

The timer has a second tick source. In this mode, the counter ignores the divider and instead counts rising edges of an asynchronous trigger pin, after the pin has been resynchronised to the clock. Software can load the counter directly. A divider value written while the timer runs is held back until the divider completes its current cycle, so a running period is never cut short.

Register map (3-bit address):

| Address | Register | Bits used |
|---|---|---|
| 0 | CTRL | bit0 run, bit1 external trigger select |
| 1 | IRQEN | bit0 interrupt enable, bit1 DMA enable |
| 2 | PSC | divider value |
| 3 | ARR | terminal count |
| 4 | CNT | direct counter load |
| 5 | STATUS | bit0 update flag |

Top module: `tick_timer`

## Requirements
- R1: After reset, cnt_o is 0 and uif_o, irq_o and dma_req_o are 0. The timer is stopped (CTRL bit0 = 0), and PSC and the interrupt/DMA enables are 0.
- R2: While CTRL bit0 is 0, the counter holds its value and no update event occurs. Trigger edges are also ignored while stopped, and the internal divider is held at its start.
- R3: With CTRL bit0 = 1 and CTRL bit1 = 0, the counter advances once every PSC+1 clock cycles. The first increment appears PSC+1 cycles after the edge at which the run bit is written.
- R4: A tick that finds the counter at or above ARR loads 0 instead of incrementing, and sets the update flag (STATUS bit0, seen on uif_o). With ARR = N-1, the count therefore repeats every N ticks.
- R5: When IRQEN bit1 is 1, dma_req_o is high for exactly one cycle, in the cycle after the wrap edge. When IRQEN bit1 is 0, dma_req_o stays 0.
- R6: irq_o equals the update flag ANDed with IRQEN bit0.
- R7: The update flag stays set until STATUS is written with bit0 = 0. Writing STATUS with bit0 = 1 leaves the flag unchanged.
- R8: A write to CNT loads the counter at that edge. If a tick falls on the same edge, the load wins.
- R9: A PSC write takes effect at once while the timer is stopped. While the timer is running, the write takes effect only when the divider next wraps.
- R10: With CTRL bits 1:0 = 11, the counter ignores PSC and advances once per rising edge of trig_i. The count changes on the third clock edge after trig_i rises, and a level held high counts only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | DATA_W (16) | Register write data |
| trig_i | input | 1 | Asynchronous external trigger |
| cnt_o | output | CNT_W (16) | Current counter value |
| uif_o | output | 1 | Sticky update flag |
| irq_o | output | 1 | Update interrupt |
| dma_req_o | output | 1 | One-cycle update DMA request |

## Verification
The bench builds the timer with its default parameters: 16-bit data, counter and divider, and a two-stage trigger synchroniser. The 16-bit counter lets the bench load a value well above the terminal count, which brings the "at or above ARR" wrap of R4 within reach. The 16-bit divider lets the bench run several prescale ratios, while keeping each scoreboard run to a few dozen cycles. With the two-stage synchroniser, the three-edge trigger latency of R10 can be checked exactly at the ports.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_IRQEN  = 3'd1,
    A_PSC    = 3'd2,
    A_ARR    = 3'd3,
    A_CNT    = 3'd4,
    A_STATUS = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic ext;
    logic run;
  } ctrl_t;

  typedef struct packed {
    logic upd_de;
    logic upd_ie;
  } ien_t;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output ctrl_t             ctrl_o,
  output ien_t              ien_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic [CNT_W-1:0]  arr_o,
  output logic              cnt_ld_o,
  output logic [CNT_W-1:0]  cnt_ld_val_o,
  output logic              flag_clr_o
);
  ctrl_t            ctrl_q;
  ien_t             ien_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] arr_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      psc_q  <= '0;
      arr_q  <= '1;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_CTRL:  ctrl_q <= ctrl_t'(wr_data_i[1:0]);
        A_IRQEN: ien_q  <= ien_t'(wr_data_i[1:0]);
        A_PSC:   psc_q  <= wr_data_i[PSC_W-1:0];
        A_ARR:   arr_q  <= wr_data_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  assign ctrl_o       = ctrl_q;
  assign ien_o        = ien_q;
  assign psc_o        = psc_q;
  assign arr_o        = arr_q;
  assign cnt_ld_o     = wr_en_i && (wr_addr_i == A_CNT);
  assign cnt_ld_val_o = wr_data_i[CNT_W-1:0];
  assign flag_clr_o   = wr_en_i && (wr_addr_i == A_STATUS) && !wr_data_i[0];

  // R1: nothing runs straight out of reset
  p_stopped_after_reset_r1: assert property (@(posedge clk_i)
    rst_i |=> (ctrl_q == '0) && (ien_q == '0) && (psc_q == '0));
endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  input  logic             ext_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] div_q;
  logic [PSC_W-1:0] lim_q;
  logic             active;
  logic             wrap;

  assign active = run_i && !ext_i;
  assign wrap   = active && (div_q == lim_q);
  assign tick_o = wrap;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      div_q <= '0;
      lim_q <= '0;
    end else if (!active) begin
      div_q <= '0;
      lim_q <= psc_i;
    end else if (wrap) begin
      div_q <= '0;
      lim_q <= psc_i;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R3: divider never passes its active limit
  p_div_in_range_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    active |-> (div_q <= lim_q));
  // R9: the active limit only moves at a wrap while running
  p_limit_held_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (active && !wrap) |=> $stable(lim_q));
endmodule

// File: rtl/timer_trig_edge.sv
module timer_trig_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic trig_i,
  output logic rise_o
);
  localparam int LAST = SYNC_STAGES;
  logic [LAST:0] sh_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sh_q[0] <= 1'b0;
    else       sh_q[0] <= trig_i;
  end

  for (genvar g = 1; g <= LAST; g++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (rst_i) sh_q[g] <= 1'b0;
      else       sh_q[g] <= sh_q[g-1];
    end
  end

  assign rise_o = sh_q[LAST-1] && !sh_q[LAST];

  // R10: one pulse per rising edge
  p_rise_single_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_o |=> !rise_o);
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             flag_clr_i,
  input  logic             upd_de_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uif_o,
  output logic             dma_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             uif_q;
  logic             dma_q;
  logic             upd;

  assign upd = tick_i && !ld_i && (cnt_q >= arr_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      uif_q <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      if (ld_i)        cnt_q <= ld_val_i;
      else if (tick_i) cnt_q <= upd ? '0 : cnt_q + 1'b1;
      if (upd)             uif_q <= 1'b1;
      else if (flag_clr_i) uif_q <= 1'b0;
      dma_q <= upd && upd_de_i;
    end
  end

  assign cnt_o = cnt_q;
  assign uif_o = uif_q;
  assign dma_o = dma_q;

  // R2: no tick and no load means the count holds
  p_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!tick_i && !ld_i) |=> $stable(cnt_q));
  // R3: a tick below the terminal count steps by one
  p_step_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && !ld_i && (cnt_q < arr_i)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R4: wrap lands on zero and raises the flag
  p_wrap_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && !ld_i && (cnt_q >= arr_i)) |=> ((cnt_q == '0) && uif_q));
  // R5: a DMA pulse only ever accompanies a set flag
  p_dma_flag_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    dma_q |-> uif_q);
  // R7: clearing without a competing wrap drops the flag
  p_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (flag_clr_i && !tick_i) |=> !uif_q);
  // R8: a load wins over a tick
  p_load_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    ld_i |=> (cnt_q == $past(ld_val_i)));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import timer_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              trig_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              uif_o,
  output logic              irq_o,
  output logic              dma_req_o
);
  ctrl_t            ctrl;
  ien_t             ien;
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] arr;
  logic             cnt_ld;
  logic [CNT_W-1:0] cnt_ld_val;
  logic             flag_clr;
  logic             psc_tick;
  logic             trig_rise;
  logic             tick;
  logic             uif;

  timer_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk_i, .rst_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_o(ctrl), .ien_o(ien), .psc_o(psc), .arr_o(arr),
    .cnt_ld_o(cnt_ld), .cnt_ld_val_o(cnt_ld_val), .flag_clr_o(flag_clr)
  );

  timer_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i, .rst_i, .run_i(ctrl.run), .ext_i(ctrl.ext),
    .psc_i(psc), .tick_o(psc_tick)
  );

  timer_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk_i, .rst_i, .trig_i, .rise_o(trig_rise)
  );

  assign tick = ctrl.run && (ctrl.ext ? trig_rise : psc_tick);

  timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_i, .tick_i(tick), .arr_i(arr),
    .ld_i(cnt_ld), .ld_val_i(cnt_ld_val), .flag_clr_i(flag_clr),
    .upd_de_i(ien.upd_de), .cnt_o, .uif_o(uif), .dma_o(dma_req_o)
  );

  assign uif_o = uif;
  assign irq_o = uif && ien.upd_ie;

  // R2: a stopped timer produces no DMA request
  p_no_dma_stopped_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ctrl.run && !cnt_ld) |=> !dma_req_o);
  // R10: in trigger mode the divider stays silent
  p_ext_no_psc_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    ctrl.ext |-> !psc_tick);
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trig = 1'b0;
  logic [15:0] cnt;
  logic        uif, irq, dma;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    cnt;
    int    uif;
    int    irq;
    int    dma;
    string req;
  } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk;

  tick_timer i_tick_timer (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .trig_i(trig), .cnt_o(cnt), .uif_o(uif),
    .irq_o(irq), .dma_req_o(dma)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per falling edge while the queue holds any
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk({e.req, " cnt"}, int'(cnt), e.cnt);
      chk({e.req, " uif"}, int'(uif), e.uif);
      chk({e.req, " irq"}, int'(irq), e.irq);
      chk({e.req, " dma"}, int'(dma), e.dma);
    end
  end

  // drives a write latched at the next rising edge, returns 1 ns after it
  task automatic wr(int a, int d);
    wr_en   = 1'b1;
    wr_addr = 3'(a);
    wr_data = 16'(d);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  // call just after the run-bit write edge; flag must be clear
  task automatic run_expect(int p, int arr, int ie, int de, int n, string req);
    for (int m = 0; m < n; m++) begin
      exp_t e;
      int   t;
      t     = m / (p + 1);
      e.cnt = t % (arr + 1);
      e.uif = (t >= arr + 1) ? 1 : 0;
      e.irq = e.uif & ie;
      e.dma = (de != 0 && t > 0 && (m % (p + 1)) == 0 && (t % (arr + 1)) == 0) ? 1 : 0;
      e.req = req;
      sbq.push_back(e);
    end
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setup(int p, int arr, int ien);
    wr(0, 0);
    wr(2, p);
    wr(3, arr);
    wr(1, ien);
    wr(5, 0);
    wr(4, 0);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog act=1 exp=0");
    finish_run();
  end

  initial begin
    int held;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 cnt", int'(cnt), 0);
    chk("R1 uif", int'(uif), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 dma", int'(dma), 0);
    @(posedge clk); #1;

    // R2: programmed but not running
    wr(3, 5);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R2 stopped cnt", int'(cnt), 0);
    @(posedge clk); #1;

    // R4 with both enables, full-rate ticks
    setup(0, 4, 3);
    wr(0, 1);
    run_expect(0, 4, 1, 1, 14, "R4");
    wr(0, 0);
    @(negedge clk);
    held = int'(cnt);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R2 hold", int'(cnt), held);
    chk("R6 irq set", int'(irq), 1);
    @(posedge clk); #1;
    wr(5, 1);
    @(negedge clk);
    chk("R7 write one keeps flag", int'(uif), 1);
    @(posedge clk); #1;
    wr(5, 0);
    @(negedge clk);
    chk("R7 cleared uif", int'(uif), 0);
    chk("R7 cleared irq", int'(irq), 0);
    @(posedge clk); #1;
    wr(5, 1);
    @(negedge clk);
    chk("R7 write one no set", int'(uif), 0);
    @(posedge clk); #1;

    // R3 divide by 3, DMA only (R6 irq stays low)
    setup(2, 3, 2);
    wr(0, 1);
    run_expect(2, 3, 0, 1, 40, "R3 R6");

    // R5: DMA disabled, interrupt enabled
    setup(1, 2, 1);
    wr(0, 1);
    run_expect(1, 2, 1, 0, 20, "R5");

    // R9: divider change while running waits for a wrap
    setup(3, 100, 0);
    wr(0, 1);
    wr(2, 1);
    repeat (3) @(posedge clk);
    @(negedge clk); chk("R9 cnt e4", int'(cnt), 1);
    @(negedge clk); chk("R9 cnt e5", int'(cnt), 1);
    @(negedge clk); chk("R9 cnt e6", int'(cnt), 2);
    @(negedge clk); chk("R9 cnt e7", int'(cnt), 2);
    @(negedge clk); chk("R9 cnt e8", int'(cnt), 3);

    // R8: load on a tick edge, then wrap from above ARR (R4)
    wr(3, 7);
    wr(4, 20);
    @(negedge clk); chk("R8 load priority", int'(cnt), 20);
    @(negedge clk); chk("R8 load held", int'(cnt), 20);
    @(negedge clk);
    chk("R4 above arr wraps", int'(cnt), 0);
    chk("R4 above arr flag", int'(uif), 1);
    @(posedge clk); #1;

    // R10: trigger edges, divider ignored
    setup(4, 100, 0);
    wr(0, 3);
    trig = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); chk("R10 latency before", int'(cnt), 0);
    @(negedge clk); chk("R10 latency after", int'(cnt), 1);
    repeat (10) @(posedge clk);
    @(negedge clk); chk("R10 level counts once", int'(cnt), 1);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1 trig = 1'b0;
      repeat (3) @(posedge clk);
      #1 trig = 1'b1;
      repeat (4) @(posedge clk);
    end
    @(negedge clk); chk("R10 pulse count", int'(cnt), 4);
    @(posedge clk); #1;
    wr(0, 0);
    trig = 1'b0;
    repeat (3) @(posedge clk);
    #1 trig = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk); chk("R2 trigger ignored when stopped", int'(cnt), 4);

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule